// File: doc/BRIEF.md
# Microcoded Control Step Sequencer and Microword Decoder

This block is the control unit of a small 16-bit microcoded processor. A three-bit step counter advances on every clock. It is joined below the current opcode to form an eleven-bit micro-program address, which goes to an external microcode store. The store returns a 16-bit microword. The block registers that word and decodes the registered copy into several outputs: one-hot bus-source and bus-destination strobes, six ALU function controls, a step-reset indication, and the drive of an immediate byte from the instruction register onto the 16-bit bus.

The source-select field is shared with the ALU function field. One ALU-select bit decides which meaning applies, and while the ALU drives the bus the source decoder is switched off. The destination decoder stays live during ALU words, so an ALU result can always be written somewhere. The step reset has its own microword bit and is sampled at the clock edge. Because of this, a change in the ALU-select bit can never end an instruction early. An instruction may use from one to eight steps.

Top module: `uctl_core`

## Requirements
- R1: `uaddr_o[10:3]` always equals `opcode_i`, and `uaddr_o[2:0]` is the current step count.
- R2: When the microword fetched in a cycle has bit 4 clear, the step count becomes the old count plus one, modulo 8, at the next clock edge.
- R3: When the fetched microword has bit 4 (step reset) set, the next step count is 0. In the following cycle `step_rst_o` is 1.
- R4: Bits 15 to 5 and 3 to 0 of the microword never affect the step count. In particular, bit 11 set together with bit 15 (the ALU's negate-Y control) neither resets the step nor raises `step_rst_o`.
- R5: In the cycle after a word is fetched, `src_o` is one-hot at the index held in bits 14:12 when bit 15 is 0 and bit 2 (source enable) is 1. Otherwise `src_o` is all zero.
- R6: In the cycle after a word with bit 15 set is fetched, `alu_oe_o` is 1 and `alu_fn_o` equals bits 14:9 of that word, with negate-Y at `alu_fn_o[2]`. With bit 15 clear, `alu_oe_o` is 0 and `alu_fn_o` is 0.
- R7: In the cycle after a word is fetched, `dst_o` is one-hot at the index held in bits 7:5 when bit 3 (destination enable) is 1, whatever the value of bit 15. Otherwise `dst_o` is zero. Destination 7 is the device-input strobe.
- R8: When source 6 is selected, `imm_oe_n_o` is 0 and `imm_data_o` is `{8'h00, ir_lo_i}`. When source 7 is selected, `imm_oe_n_o` is 0 and `imm_data_o` is `{8'hFF, ir_lo_i}`. Otherwise `imm_oe_n_o` is 1 and `imm_data_o` is 0.
- R9: While `rst` is high at a clock edge, the step becomes 0 and all strobes become inactive after that edge: `src_o`, `dst_o`, `alu_oe_o`, `alu_fn_o` and `step_rst_o` are 0, and `imm_oe_n_o` is 1. The microword input is ignored during reset.
- R10: In every cycle `src_o` and `dst_o` each have at most one bit set, and `src_o` is zero whenever `alu_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode_i | input | 8 | Opcode of the current instruction |
| uword_i | input | 16 | Microword returned by the microcode store for `uaddr_o` |
| ir_lo_i | input | 8 | Low byte of the instruction word |
| uaddr_o | output | 11 | Micro-program address: {opcode, step} |
| src_o | output | 8 | One-hot bus-source strobes |
| dst_o | output | 8 | One-hot bus-destination strobes; bit 7 is device input |
| alu_oe_o | output | 1 | ALU drives the bus |
| alu_fn_o | output | 6 | ALU function controls; bit 2 is negate-Y |
| step_rst_o | output | 1 | The executing step ends the instruction |
| imm_oe_n_o | output | 1 | Immediate-byte bus drive enable, active low |
| imm_data_o | output | 16 | Immediate value with zero or ones fill |

## Verification
The assertions check, on every cycle, the properties that must hold in any state:

- both strobe groups stay one-hot or empty;
- the ALU excludes every other source;
- the step either increments or returns to zero, according to the sampled reset bit;
- an enabled destination still fires under an ALU word;
- an enabled immediate drive carries the instruction byte.

Some behaviour can only be shown by the bench's scenarios:

- the exact mapping of each of the 65536 microword values to strobes, fill pattern and function bits;
- step sequences from a microcode store that ends an instruction after three steps;
- the proof that negate-Y words never shorten an instruction.

// File: rtl/uctl_pkg.sv
package uctl_pkg;
   // Default microword layout. The function field must enclose the source
   // field, and the step-reset bit must lie outside the function field.
   localparam int UW_W_D       = 16;
   localparam int ALU_BIT_D    = 15;
   localparam int FN_LSB_D     = 9;
   localparam int SRC_LSB_D    = 12;
   localparam int DST_LSB_D    = 5;
   localparam int RT_BIT_D     = 4;
   localparam int DST_EN_BIT_D = 3;
   localparam int SRC_EN_BIT_D = 2;

   typedef struct packed {
      logic alu;
      logic rt;
      logic src_en;
      logic dst_en;
   } uw_flags_t;
endpackage

// File: rtl/uctl_seq.sv
module uctl_seq #(
   parameter int OP_W   = 8,
   parameter int STEP_W = 3,
   localparam int ADDR_W = OP_W + STEP_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [OP_W-1:0]   opcode_i,
   input  logic              rt_i,
   output logic [ADDR_W-1:0] uaddr_o
);
   logic [STEP_W-1:0] step_q;

   if (STEP_W < 1) begin : g_bad_step
      $error("uctl_seq: STEP_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst || rt_i) step_q <= '0;
      else             step_q <= step_q + 1'b1;
   end

   assign uaddr_o = {opcode_i, step_q};

   // R2
   step_inc_chk: assert property (@(posedge clk) disable iff (rst)
      !rt_i |=> (step_q == STEP_W'($past(step_q) + 1'b1)));

   // R3
   step_clr_chk: assert property (@(posedge clk) disable iff (rst)
      rt_i |=> (step_q == '0));

   // R9
   step_rst_chk: assert property (@(posedge clk)
      rst |=> (step_q == '0));
endmodule

// File: rtl/uctl_dec.sv
module uctl_dec #(
   parameter int SEL_W = 3,
   localparam int N = 1 << SEL_W
) (
   input  logic             en_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic [N-1:0]     strb_o
);
   for (genvar i = 0; i < N; i++) begin : g_line
      assign strb_o[i] = en_i && (sel_i == SEL_W'(i));
   end
endmodule

// File: rtl/uctl_imm.sv
module uctl_imm #(
   parameter int BUS_W  = 16,
   parameter int IMM_W  = 8,
   parameter int N_SRC  = 8,
   parameter int LO_SRC = 6,
   parameter int HI_SRC = 7
) (
   input  logic [N_SRC-1:0] src_i,
   input  logic [IMM_W-1:0] ir_lo_i,
   output logic             oe_n_o,
   output logic [BUS_W-1:0] data_o
);
   logic oe;
   logic unused_src;

   if (BUS_W < IMM_W) begin : g_bad_bus
      $error("uctl_imm: BUS_W must not be smaller than IMM_W");
   end
   if (LO_SRC >= N_SRC || HI_SRC >= N_SRC || LO_SRC == HI_SRC) begin : g_bad_idx
      $error("uctl_imm: immediate source indices invalid");
   end

   assign oe         = src_i[LO_SRC] | src_i[HI_SRC];
   assign oe_n_o     = ~oe;
   assign unused_src = ^src_i;

   if (BUS_W > IMM_W) begin : g_fill
      localparam int FILL_W = BUS_W - IMM_W;
      assign data_o = oe ? {{FILL_W{src_i[HI_SRC]}}, ir_lo_i} : '0;
   end else begin : g_nofill
      assign data_o = oe ? ir_lo_i : '0;
   end
endmodule

// File: rtl/uctl_core.sv
module uctl_core #(
   parameter int OP_W       = 8,
   parameter int STEP_W     = 3,
   parameter int SEL_W      = 3,
   parameter int FN_W       = 6,
   parameter int BUS_W      = 16,
   parameter int IMM_W      = 8,
   parameter int UW_W       = uctl_pkg::UW_W_D,
   parameter int ALU_BIT    = uctl_pkg::ALU_BIT_D,
   parameter int FN_LSB     = uctl_pkg::FN_LSB_D,
   parameter int SRC_LSB    = uctl_pkg::SRC_LSB_D,
   parameter int DST_LSB    = uctl_pkg::DST_LSB_D,
   parameter int RT_BIT     = uctl_pkg::RT_BIT_D,
   parameter int DST_EN_BIT = uctl_pkg::DST_EN_BIT_D,
   parameter int SRC_EN_BIT = uctl_pkg::SRC_EN_BIT_D,
   parameter int IMM_LO_SRC = 6,
   parameter int IMM_HI_SRC = 7,
   localparam int ADDR_W = OP_W + STEP_W,
   localparam int N_STRB = 1 << SEL_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [OP_W-1:0]   opcode_i,
   input  logic [UW_W-1:0]   uword_i,
   input  logic [IMM_W-1:0]  ir_lo_i,
   output logic [ADDR_W-1:0] uaddr_o,
   output logic [N_STRB-1:0] src_o,
   output logic [N_STRB-1:0] dst_o,
   output logic              alu_oe_o,
   output logic [FN_W-1:0]   alu_fn_o,
   output logic              step_rst_o,
   output logic              imm_oe_n_o,
   output logic [BUS_W-1:0]  imm_data_o
);
   import uctl_pkg::*;

   // Layout checks: the step-reset bit must not share a function bit.
   if (FN_LSB + FN_W > UW_W || DST_LSB + SEL_W > UW_W) begin : g_bad_fit
      $error("uctl_core: microword fields exceed UW_W");
   end
   if (SRC_LSB < FN_LSB || SRC_LSB + SEL_W > FN_LSB + FN_W) begin : g_bad_share
      $error("uctl_core: source field must lie inside the function field");
   end
   if ((RT_BIT >= FN_LSB && RT_BIT < FN_LSB + FN_W) || RT_BIT == ALU_BIT) begin : g_bad_rt
      $error("uctl_core: step-reset bit must have a bit of its own");
   end

   logic [UW_W-1:0] uw_q;
   uw_flags_t       fl;
   logic            unused_uw;

   always_ff @(posedge clk) begin
      if (rst) uw_q <= '0;
      else     uw_q <= uword_i;
   end

   assign fl.alu    = uw_q[ALU_BIT];
   assign fl.rt     = uw_q[RT_BIT];
   assign fl.src_en = uw_q[SRC_EN_BIT];
   assign fl.dst_en = uw_q[DST_EN_BIT];
   assign unused_uw = ^uw_q;

   uctl_seq #(.OP_W(OP_W), .STEP_W(STEP_W)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .opcode_i (opcode_i),
      .rt_i     (uword_i[RT_BIT]),
      .uaddr_o  (uaddr_o)
   );

   uctl_dec #(.SEL_W(SEL_W)) u_src (
      .en_i   (fl.src_en && !fl.alu),
      .sel_i  (uw_q[SRC_LSB +: SEL_W]),
      .strb_o (src_o)
   );

   uctl_dec #(.SEL_W(SEL_W)) u_dst (
      .en_i   (fl.dst_en),
      .sel_i  (uw_q[DST_LSB +: SEL_W]),
      .strb_o (dst_o)
   );

   uctl_imm #(.BUS_W(BUS_W), .IMM_W(IMM_W), .N_SRC(N_STRB),
              .LO_SRC(IMM_LO_SRC), .HI_SRC(IMM_HI_SRC)) u_imm (
      .src_i   (src_o),
      .ir_lo_i (ir_lo_i),
      .oe_n_o  (imm_oe_n_o),
      .data_o  (imm_data_o)
   );

   assign alu_oe_o   = fl.alu;
   assign alu_fn_o   = fl.alu ? uw_q[FN_LSB +: FN_W] : '0;
   assign step_rst_o = fl.rt;

   // R10
   src_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(src_o));
   // R10
   dst_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(dst_o));
   // R10
   alu_excl_chk: assert property (@(posedge clk) disable iff (rst)
      alu_oe_o |-> (src_o == '0 && imm_oe_n_o));
   // R7
   dst_live_chk: assert property (@(posedge clk) disable iff (rst)
      uword_i[DST_EN_BIT] |=> (dst_o != '0));
   // R3
   rt_flag_chk: assert property (@(posedge clk) disable iff (rst)
      uword_i[RT_BIT] |=> step_rst_o);
   // R4
   negy_norst_chk: assert property (@(posedge clk) disable iff (rst)
      (uword_i[ALU_BIT] && !uword_i[RT_BIT]) |=> (!step_rst_o && alu_oe_o));
   // R8
   imm_byte_chk: assert property (@(posedge clk) disable iff (rst)
      !imm_oe_n_o |-> (imm_data_o[IMM_W-1:0] == ir_lo_i));
   // R9
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (src_o == '0 && dst_o == '0 && !alu_oe_o && !step_rst_o && imm_oe_n_o));
endmodule

// File: tb/sim_uctl_core.sv
module sim_uctl_core;
   localparam int CLK_P = 10;
   localparam int WD_CYC = 150000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  opcode_i = '0;
   logic [15:0] uword_i = '1;
   logic [7:0]  ir_lo_i = '0;
   logic [10:0] uaddr_o;
   logic [7:0]  src_o, dst_o;
   logic        alu_oe_o, step_rst_o, imm_oe_n_o;
   logic [5:0]  alu_fn_o;
   logic [15:0] imm_data_o;

   int   errs = 0;
   int   checks = 0;
   logic done = 1'b0;
   logic [2:0] exp_step = '0;

   always #(CLK_P/2) clk = ~clk;

   uctl_core u0 (
      .clk(clk), .rst(rst), .opcode_i(opcode_i), .uword_i(uword_i),
      .ir_lo_i(ir_lo_i), .uaddr_o(uaddr_o), .src_o(src_o), .dst_o(dst_o),
      .alu_oe_o(alu_oe_o), .alu_fn_o(alu_fn_o), .step_rst_o(step_rst_o),
      .imm_oe_n_o(imm_oe_n_o), .imm_data_o(imm_data_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Called at a negedge; returns at the following negedge.
   task automatic run_word(input logic [15:0] w, input logic [7:0] op,
                           input logic [7:0] ir, input string step_req);
      logic       alu;
      logic       imm;
      logic [7:0] e_src, e_dst;
      logic [15:0] e_data;
      opcode_i = op;
      uword_i  = w;
      ir_lo_i  = ir;
      #1;
      chk("R1", {24'd0, uaddr_o[10:3]}, {24'd0, op});
      chk(step_req, {29'd0, uaddr_o[2:0]}, {29'd0, exp_step});
      @(posedge clk);
      exp_step = w[4] ? 3'd0 : exp_step + 3'd1;
      @(negedge clk);
      alu   = w[15];
      e_src = (!alu && w[2]) ? (8'd1 << w[14:12]) : 8'd0;
      e_dst = w[3] ? (8'd1 << w[7:5]) : 8'd0;
      imm   = !alu && w[2] && (w[14:13] == 2'b11);
      e_data = imm ? {(w[12] ? 8'hFF : 8'h00), ir} : 16'h0000;
      chk("R5", {24'd0, src_o}, {24'd0, e_src});
      chk("R7", {24'd0, dst_o}, {24'd0, e_dst});
      chk("R6", {25'd0, alu_oe_o, alu_fn_o}, {25'd0, alu, (alu ? w[14:9] : 6'd0)});
      chk("R8", {15'd0, imm_oe_n_o, imm_data_o}, {15'd0, !imm, e_data});
      chk("R3", {31'd0, step_rst_o}, {31'd0, w[4]});
      chk("R10", {31'd0, ($countones(src_o) <= 1 && $countones(dst_o) <= 1)}, 32'd1);
   endtask

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [2:0] prev_rt_pos;
      string      lab;
      logic [15:0] w;
      opcode_i = 8'hC3;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: all-ones microword presented during reset is ignored
      chk("R9", {21'd0, uaddr_o}, {21'd0, 8'hC3, 3'd0});
      chk("R9", {16'd0, src_o, dst_o}, 32'd0);
      chk("R9", {24'd0, alu_oe_o, alu_fn_o, step_rst_o}, 32'd0);
      chk("R9", {15'd0, imm_oe_n_o, imm_data_o}, {15'd0, 1'b1, 16'h0000});
      rst = 1'b0;
      uword_i = '0;
      exp_step = '0;
      prev_rt_pos = 3'd0;
      // Sweep every microword value
      lab = "R2";
      for (int i = 0; i < 65536; i++) begin
         w = i[15:0];
         run_word(w, i[7:0] ^ 8'h5A, i[15:8] ^ i[7:0], lab);
         if (w[4])                 lab = "R3";
         else if (w[15] && w[11])  lab = "R4";
         else                      lab = "R2";
      end
      // Store-driven run: three-step instructions, negate-Y words in between
      lab = "R2";
      for (int k = 0; k < 12; k++) begin
         if (exp_step == 3'd2) w = 16'h0010;
         else                  w = 16'h8800 | 16'h00E8;
         run_word(w, 8'h21, 8'h7E, lab);
         lab = w[4] ? "R3" : "R4";
         prev_rt_pos = exp_step;
      end
      chk("R3", {29'd0, prev_rt_pos}, {29'd0, 3'd0});
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule